// File: doc/BRIEF.md
# Power-Down Entry and Exit Controller

This block decides whether a power-down request from instruction execution actually puts the chip into power-down, and when power-down ends. It runs on an always-on clock and drives a single power-down state output that the clock gating logic uses to stop the main clocks. The NMI pin and a small set of fast external interrupt pins reach it through two-flop synchronisers. Each external pin has its own enable bit and its own active level.

A mode bit selects one of two behaviours. With the mode bit at 0, a request takes effect only while the NMI pin is low, and only reset ends power-down. With the mode bit at 1, a request takes effect only while every enabled external pin is at its inactive level. Power-down then ends as soon as any enabled pin becomes active, or on reset. The mode is captured when power-down is entered, so later changes to the mode bit do not change how the current power-down ends.

A request that fails its entry condition changes nothing except a one-cycle ignored pulse. The block has no data stream, so every port is a plain level or strobe and there is no valid/ready handshake.

Top module: `pdc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, pd_active and req_ignored are 0, which is the RUN state.
- R2: A pd_req strobe sampled in RUN with the entry condition met sets pd_active in the next cycle. Without a strobe, pd_active never rises.
- R3: With cfg_ext_wake at 0, the entry condition is that the synchronised nmi_pin is low. The external pins have no effect on entry in this mode.
- R4: With cfg_ext_wake at 1, the entry condition is that no enabled pin is active. Pin i is active when ext_pin[i] equals ext_act_hi[i], so 1 means active high and 0 means active low. nmi_pin has no effect in this mode.
- R5: A strobe in RUN that fails the entry condition leaves pd_active at 0. It raises req_ignored for exactly one cycle, in the cycle after the strobe.
- R6: A power-down entered with the mode bit at 0 ends only on reset. Changes on nmi_pin or on any external pin leave pd_active at 1.
- R7: A power-down entered with the mode bit at 1 ends when any enabled pin becomes active. pd_active falls on the third rising clock edge after the pin change: two synchroniser stages, then the state register.
- R8: A pin whose ext_en bit is 0 is ignored for both entry and wake-up.
- R9: A pd_req strobe during power-down has no effect and produces no req_ignored pulse.
- R10: The mode is latched at entry. Changing cfg_ext_wake during power-down does not change which wake-up sources apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | One-cycle strobe from the power-down instruction |
| cfg_ext_wake | input | 1 | Mode: 0 = NMI-gated entry with reset-only exit; 1 = external pin entry and wake |
| nmi_pin | input | 1 | Asynchronous NMI pin level |
| ext_pin | input | N_EXT | Asynchronous fast external interrupt pin levels |
| ext_en | input | N_EXT | Per-pin enable |
| ext_act_hi | input | N_EXT | Per-pin active level (1 = high is active) |
| pd_active | output | 1 | 1 while in power-down; used to gate the main clocks |
| req_ignored | output | 1 | One-cycle pulse when a request failed its condition |

## Verification
The hardest situation to reach from the ports is a wake-up decision. It needs a successful entry in the right latched mode, a settled synchroniser, and then a pin pattern that splits enabled pins from disabled ones. The bench sweeps every combination of mode, NMI level, pin levels, enables and polarities on a three-pin configuration. For each combination it resets, settles the pins and issues a request. After a successful entry it flips the mode bit and repeats the request. It then drives a pattern where only disabled pins are active, and finally one where every pin is active, checking the exact edge on which pd_active falls.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {
    ST_RUN = 1'b0,
    ST_PD  = 1'b1
  } pd_state_e;
endpackage

// File: rtl/pdc_sync.sv
// Multi-stage level synchroniser for asynchronous pins.
module pdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pdc_eval.sv
// Combinational evaluation of entry and wake-up conditions.
module pdc_eval #(
  parameter int N_EXT = 4
) (
  input  logic             mode_now,
  input  logic             nmi_s,
  input  logic [N_EXT-1:0] pin_s,
  input  logic [N_EXT-1:0] en,
  input  logic [N_EXT-1:0] act_hi,
  output logic             entry_ok,
  output logic             wake_any
);
  logic [N_EXT-1:0] pin_active;

  generate
    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
      assign pin_active[i] = en[i] & ~(pin_s[i] ^ act_hi[i]);
    end
  endgenerate

  assign wake_any = |pin_active;

  always_comb begin
    if (mode_now) entry_ok = ~wake_any;
    else          entry_ok = ~nmi_s;
  end
endmodule

// File: rtl/pdc_fsm.sv
// RUN / POWERDOWN state machine with mode latch and ignored-request pulse.
module pdc_fsm
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic mode_now,
  input  logic entry_ok,
  input  logic wake_any,
  output logic pd_on,
  output logic ignored,
  output logic mode_lat
);
  pd_state_e st_q, st_d;
  logic      mode_q, mode_d;
  logic      ign_q, ign_d;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    ign_d  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (req) begin
          if (entry_ok) begin
            st_d   = ST_PD;
            mode_d = mode_now;
          end else begin
            ign_d = 1'b1;
          end
        end
      end
      ST_PD: begin
        if (mode_q && wake_any) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      mode_q <= 1'b0;
      ign_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      ign_q  <= ign_d;
    end
  end

  assign pd_on    = (st_q == ST_PD);
  assign ignored  = ign_q;
  assign mode_lat = mode_q;
endmodule

// File: rtl/pdc_ctrl.sv
// Top: power-down entry and exit controller.
module pdc_ctrl #(
  parameter int N_EXT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             cfg_ext_wake,
  input  logic             nmi_pin,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_EXT-1:0] ext_act_hi,
  output logic             pd_active,
  output logic             req_ignored
);
  localparam int SW = N_EXT + 1;

  logic [SW-1:0]    raw_pins, syn_pins;
  logic             nmi_s;
  logic [N_EXT-1:0] ext_s;
  logic             entry_ok, wake_any, mode_lat;

  assign raw_pins = {nmi_pin, ext_pin};
  assign nmi_s    = syn_pins[SW-1];
  assign ext_s    = syn_pins[N_EXT-1:0];

  pdc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_pins),
    .q_sync  (syn_pins)
  );

  pdc_eval #(.N_EXT(N_EXT)) u_eval (
    .mode_now (cfg_ext_wake),
    .nmi_s    (nmi_s),
    .pin_s    (ext_s),
    .en       (ext_en),
    .act_hi   (ext_act_hi),
    .entry_ok (entry_ok),
    .wake_any (wake_any)
  );

  pdc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (pd_req),
    .mode_now (cfg_ext_wake),
    .entry_ok (entry_ok),
    .wake_any (wake_any),
    .pd_on    (pd_active),
    .ignored  (req_ignored),
    .mode_lat (mode_lat)
  );
endmodule

// File: rtl/pdc_ctrl_chk.sv
module pdc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_req,
  input logic pd_active,
  input logic req_ignored,
  input logic mode_lat
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!pd_active && !req_ignored);
    end
  end

  // R2
  entry_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> $past(pd_req));

  // R5
  ignored_after_run_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ignored |-> ($past(pd_req) && !$past(pd_active) && !pd_active));

  // R9
  no_ignore_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_active) && pd_req) |=> !req_ignored);

  // R6
  mode0_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_active) |-> $past(mode_lat));

  // R10
  mode_stable_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_active) && pd_active) |-> $stable(mode_lat));
endmodule

bind pdc_ctrl pdc_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pd_req      (pd_req),
  .pd_active   (pd_active),
  .req_ignored (req_ignored),
  .mode_lat    (mode_lat)
);

// File: tb/tb_pdc_ctrl.sv
module tb_pdc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0;
  logic cfg_ext_wake = 1'b0;
  logic nmi_pin = 1'b0;
  logic [N-1:0] ext_pin = '0;
  logic [N-1:0] ext_en = '0;
  logic [N-1:0] ext_act_hi = '0;
  logic pd_active, req_ignored;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdc_ctrl #(.N_EXT(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .cfg_ext_wake(cfg_ext_wake),
    .nmi_pin(nmi_pin), .ext_pin(ext_pin), .ext_en(ext_en),
    .ext_act_hi(ext_act_hi), .pd_active(pd_active), .req_ignored(req_ignored)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b mode=%0b nmi=%0b pin=%b en=%b pol=%b",
               tag, got, exp, cfg_ext_wake, nmi_pin, ext_pin, ext_en, ext_act_hi);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    pd_req = 1'b1;
    nwait(1);
    pd_req = 1'b0;
  endtask

  initial begin
    nwait(2);
    chk(pd_active, 1'b0, "R1 pd_active in reset");
    chk(req_ignored, 1'b0, "R1 req_ignored in reset");
    for (int m = 0; m < 2; m++) begin
      for (int nm = 0; nm < 2; nm++) begin
        for (int en = 0; en < (1 << N); en++) begin
          for (int pol = 0; pol < (1 << N); pol++) begin
            for (int pv = 0; pv < (1 << N); pv++) begin
              logic [N-1:0] act;
              logic enter;
              rst_n = 1'b0;
              cfg_ext_wake = m[0];
              nmi_pin = nm[0];
              ext_en = en[N-1:0];
              ext_act_hi = pol[N-1:0];
              ext_pin = pv[N-1:0];
              nwait(1);
              rst_n = 1'b1;
              nwait(4);
              chk(pd_active, 1'b0, "R1/R2 no entry without strobe");
              act = ~(ext_pin ^ ext_act_hi) & ext_en;
              enter = m[0] ? (act == '0) : !nm[0];
              pulse_req();
              chk(pd_active, enter, m[0] ? "R4/R8 entry decision" : "R3 entry decision");
              chk(req_ignored, !enter, "R5 ignored pulse");
              nwait(1);
              chk(req_ignored, 1'b0, "R5 pulse one cycle");
              chk(pd_active, enter, "R2 state held");
              if (enter) begin
                cfg_ext_wake = ~m[0];
                pulse_req();
                chk(pd_active, 1'b1, "R9 req in pd");
                chk(req_ignored, 1'b0, "R9 no pulse in pd");
                ext_pin = (ext_act_hi & ~ext_en) | (~ext_act_hi & ext_en);
                nwait(4);
                chk(pd_active, 1'b1, "R8 disabled pins no wake");
                nmi_pin = ~nmi_pin;
                ext_pin = ext_act_hi;
                nwait(2);
                chk(pd_active, 1'b1, "R7 not before third edge");
                nwait(1);
                chk(pd_active, !(m[0] && en != 0),
                    m[0] ? "R7/R10 wake on enabled pin" : "R6/R10 mode0 reset-only exit");
                if (!m[0]) begin
                  rst_n = 1'b0;
                  nwait(1);
                  chk(pd_active, 1'b0, "R6 reset exits");
                end
              end
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule